// File: doc/BRIEF.md
# Accumulator ALU with instruction decode

This block is the decode and execute stage of a small 8-bit accumulator machine, built as one combinational stage. It takes a 13-bit instruction word, the accumulator value, the value of the addressed register as read from the register file, and the current carry flag. In the same cycle it gives back the result byte, which destination takes it (accumulator or register), the write strobes, new Z, C and DC flag values with one update enable per flag, and a request to skip the next instruction.

Register-file instructions have bit 12 clear. Bits 11:6 select the operation and bits 5:0 address a register. In most of these forms the lowest opcode bit (bit 6) sends the result to the register rather than to the accumulator. Literal instructions have bit 12 set, take their opcode from bits 11:8 and an 8-bit constant k from bits 7:0, and always write the accumulator. Program flow, the register file, the stack and paging are handled elsewhere. Encodings this block does not handle decode as a no-op.

Top module: `acc_alu_core`

## Requirements
- R1: Undefined encodings cause no write, no flag enable and no skip, and give result 0. They are register-group opcode 000000, opcode 000010 with a nonzero address, and literal opcodes 00xx, 01xx, 1100 and 1110 (bits 11:8).
- R2: In register-group arithmetic, logic, move, rotate and swap forms, instr[6]=1 raises reg_we and instr[6]=0 raises acc_we. Bit set and bit clear always raise reg_we, and literal forms always raise acc_we. The two strobes are never high together, and reg_addr equals instr[5:0].
- R3: Opcodes 001110/001111 give A+R, 000100/000101 give R-A, literal 1111 gives k+A and literal 1101 gives k-A, all modulo 256. Each sets Z, C and DC. For addition, C is the carry out of bit 7 and DC the carry out of bit 3. For subtraction, C is 1 when the minuend is greater than or equal to the subtrahend, and DC is 1 when the minuend's low nibble is greater than or equal to the subtrahend's.
- R4: Register-group OR (001000/001001), AND (001010/001011) and XOR (001100/001101), and literal OR 1001, AND 1010 and XOR 1011, combine A with R or with k and enable only the Z flag.
- R5: Clear A (0x0080) and clear R (opcode 000011) write 0 with Z=1. Copy R (010000/010001), complement (010010/010011), increment (010100/010101) and decrement (000110/000111) enable only Z. Copy A into R (000001) and load literal (literal 1000) enable no flag.
- R6: Decrement-and-skip (010110/010111) and increment-and-skip (011110/011111) write R-1 or R+1, raise skip when that result is 0, and enable no flag.
- R7: Rotate right (011000/011001) gives {C, R[7:1]} with new C = R[0]. Rotate left (011010/011011) gives {R[6:0], C} with new C = R[7]. Only the C flag is enabled.
- R8: Swap (011100/011101) exchanges the two nibbles of R and enables no flag.
- R9: With instr[12:9]=0100, bit instr[8:6] of R is cleared; with 0101 it is set. The result goes to the register, with no flag enable and no skip.
- R10: With instr[12:9]=0110, skip is raised when bit instr[8:6] of R is 0; with 0111, when it is 1. Neither writes or enables any flag.
- R11: When c_we is low, c_out equals carry_in. When z_we or dc_we is low, z_out or dc_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 13 | Instruction word |
| acc_in | input | 8 | Current accumulator value |
| reg_in | input | 8 | Value of the addressed register |
| carry_in | input | 1 | Current carry flag |
| reg_addr | output | 6 | Register address field of the instruction |
| result | output | 8 | Result byte |
| dest_reg | output | 1 | 1: result goes to register, 0: to accumulator |
| acc_we | output | 1 | Accumulator write strobe |
| reg_we | output | 1 | Register write strobe |
| z_out | output | 1 | New Z flag value |
| z_we | output | 1 | Z update enable |
| c_out | output | 1 | New C flag value |
| c_we | output | 1 | C update enable |
| dc_out | output | 1 | New DC flag value |
| dc_we | output | 1 | DC update enable |
| skip | output | 1 | Skip-next request |

## Verification
Arithmetic is driven with operand pairs that are equal, that straddle each other, and that carry out of the low nibble only or out of the whole byte. These tell the two carry flags apart and catch a swapped subtraction order. The skip forms are tried with R at 1, 2 and 0xFF, and the bit tests are tried on a byte whose tested bit is the only 0. This separates a skip taken on the right condition from one taken on the inverted condition or on the wrong bit. Random instruction words, with operands drawn from corner bytes and from random values, cover the undefined encodings, the destination bit and flag enables that are off, where c_out must repeat carry_in.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW    = 8;
    localparam int AW    = 6;
    localparam int IW    = 13;
    localparam int NIB   = DW / 2;
    localparam int BW    = $clog2(DW);
    localparam int OPW   = IW - 1 - AW;

    typedef enum logic [4:0] {
        OP_NOP, OP_PASS_A, OP_ZERO, OP_SUB, OP_DEC, OP_OR, OP_AND, OP_XOR,
        OP_ADD, OP_PASS_B, OP_COM, OP_INC, OP_DECSKIP, OP_INCSKIP, OP_RRC,
        OP_RLC, OP_SWAP, OP_BCLR, OP_BSET, OP_BTST0, OP_BTST1
    } op_e;

    typedef struct packed {
        op_e  op;
        logic use_lit;
        logic to_reg;
        logic wr;
        logic z_en;
        logic c_en;
        logic dc_en;
    } ctl_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_alu_pkg::*;
(
    input  logic [IW-1:0] instr,
    output ctl_t          ctl,
    output logic [BW-1:0] bsel,
    output logic [DW-1:0] lit
);
    logic [OPW-1:0] op6;
    logic [3:0]     lop;

    assign op6  = instr[IW-2:AW];
    assign lop  = instr[IW-2:IW-5];
    assign bsel = instr[AW+BW-1:AW];
    assign lit  = instr[DW-1:0];

    always_comb begin
        ctl = '0;
        ctl.op = OP_NOP;
        if (!instr[IW-1]) begin
            ctl.to_reg = op6[0];
            if (op6[OPW-1]) begin
                unique case (op6[OPW-2:OPW-3])
                    2'b00: begin ctl.op = OP_BCLR;  ctl.wr = 1'b1; ctl.to_reg = 1'b1; end
                    2'b01: begin ctl.op = OP_BSET;  ctl.wr = 1'b1; ctl.to_reg = 1'b1; end
                    2'b10: begin ctl.op = OP_BTST0; ctl.to_reg = 1'b0; end
                    2'b11: begin ctl.op = OP_BTST1; ctl.to_reg = 1'b0; end
                endcase
            end else begin
                unique case (op6[4:1])
                    4'd0: if (op6[0]) begin ctl.op = OP_PASS_A; ctl.wr = 1'b1; end
                    4'd1: if (op6[0] || instr[AW-1:0] == '0) begin
                              ctl.op = OP_ZERO; ctl.wr = 1'b1; ctl.z_en = 1'b1;
                          end
                    4'd2: begin ctl.op = OP_SUB; ctl.wr = 1'b1;
                                ctl.z_en = 1'b1; ctl.c_en = 1'b1; ctl.dc_en = 1'b1; end
                    4'd3: begin ctl.op = OP_DEC;     ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                    4'd4: begin ctl.op = OP_OR;      ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                    4'd5: begin ctl.op = OP_AND;     ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                    4'd6: begin ctl.op = OP_XOR;     ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                    4'd7: begin ctl.op = OP_ADD; ctl.wr = 1'b1;
                                ctl.z_en = 1'b1; ctl.c_en = 1'b1; ctl.dc_en = 1'b1; end
                    4'd8: begin ctl.op = OP_PASS_B;  ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                    4'd9: begin ctl.op = OP_COM;     ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                    4'd10: begin ctl.op = OP_INC;    ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                    4'd11: begin ctl.op = OP_DECSKIP; ctl.wr = 1'b1; end
                    4'd12: begin ctl.op = OP_RRC;    ctl.wr = 1'b1; ctl.c_en = 1'b1; end
                    4'd13: begin ctl.op = OP_RLC;    ctl.wr = 1'b1; ctl.c_en = 1'b1; end
                    4'd14: begin ctl.op = OP_SWAP;   ctl.wr = 1'b1; end
                    4'd15: begin ctl.op = OP_INCSKIP; ctl.wr = 1'b1; end
                endcase
            end
        end else begin
            ctl.use_lit = 1'b1;
            unique case (lop)
                4'b1000: begin ctl.op = OP_PASS_B; ctl.wr = 1'b1; end
                4'b1001: begin ctl.op = OP_OR;  ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                4'b1010: begin ctl.op = OP_AND; ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                4'b1011: begin ctl.op = OP_XOR; ctl.wr = 1'b1; ctl.z_en = 1'b1; end
                4'b1101: begin ctl.op = OP_SUB; ctl.wr = 1'b1;
                               ctl.z_en = 1'b1; ctl.c_en = 1'b1; ctl.dc_en = 1'b1; end
                4'b1111: begin ctl.op = OP_ADD; ctl.wr = 1'b1;
                               ctl.z_en = 1'b1; ctl.c_en = 1'b1; ctl.dc_en = 1'b1; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_alu_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic [BW-1:0] bsel,
    output logic [DW-1:0] res,
    output logic          z,
    output logic          c,
    output logic          dc,
    output logic          skip
);
    logic [DW:0]     sum, diff;
    logic [NIB:0]    hsum, hdiff;
    logic [DW-1:0]   mask;

    assign sum   = {1'b0, a} + {1'b0, b};
    assign diff  = {1'b0, b} - {1'b0, a};
    assign hsum  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
    assign hdiff = {1'b0, b[NIB-1:0]} - {1'b0, a[NIB-1:0]};

    always_comb begin
        for (int i = 0; i < DW; i++) mask[i] = (bsel == i[BW-1:0]);
    end

    always_comb begin
        res  = '0;
        c    = cin;
        dc   = 1'b0;
        skip = 1'b0;
        unique case (op)
            OP_PASS_A:  res = a;
            OP_SUB:     begin res = diff[DW-1:0]; c = ~diff[DW]; dc = ~hdiff[NIB]; end
            OP_ADD:     begin res = sum[DW-1:0];  c = sum[DW];   dc = hsum[NIB];   end
            OP_DEC:     res = b - 1'b1;
            OP_INC:     res = b + 1'b1;
            OP_OR:      res = a | b;
            OP_AND:     res = a & b;
            OP_XOR:     res = a ^ b;
            OP_PASS_B:  res = b;
            OP_COM:     res = ~b;
            OP_DECSKIP: begin res = b - 1'b1; skip = (res == '0); end
            OP_INCSKIP: begin res = b + 1'b1; skip = (res == '0); end
            OP_RRC:     begin res = {cin, b[DW-1:1]}; c = b[0]; end
            OP_RLC:     begin res = {b[DW-2:0], cin}; c = b[DW-1]; end
            OP_SWAP:    res = {b[NIB-1:0], b[DW-1:NIB]};
            OP_BCLR:    res = b & ~mask;
            OP_BSET:    res = b | mask;
            OP_BTST0:   skip = ((b & mask) == '0);
            OP_BTST1:   skip = ((b & mask) != '0);
            default:    res = '0;
        endcase
        z = (res == '0);
    end

    always_comb begin
        AST_SKIP_ON_ZERO: assert (!(skip && (op == OP_DECSKIP || op == OP_INCSKIP)) || res == '0)
            else $error("skip with nonzero result"); // R6
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] reg_in,
    input  logic          carry_in,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] result,
    output logic          dest_reg,
    output logic          acc_we,
    output logic          reg_we,
    output logic          z_out,
    output logic          z_we,
    output logic          c_out,
    output logic          c_we,
    output logic          dc_out,
    output logic          dc_we,
    output logic          skip
);
    ctl_t          ctl;
    logic [BW-1:0] bsel;
    logic [DW-1:0] lit, opnd_b, res;
    logic          z_r, c_r, dc_r, skip_r;

    acc_decode u_dec (.instr(instr), .ctl(ctl), .bsel(bsel), .lit(lit));

    assign opnd_b = ctl.use_lit ? lit : reg_in;

    acc_exec u_exe (
        .op(ctl.op), .a(acc_in), .b(opnd_b), .cin(carry_in), .bsel(bsel),
        .res(res), .z(z_r), .c(c_r), .dc(dc_r), .skip(skip_r)
    );

    assign reg_addr = instr[AW-1:0];
    assign result   = ctl.wr ? res : '0;
    assign dest_reg = ctl.to_reg;
    assign acc_we   = ctl.wr & ~ctl.to_reg;
    assign reg_we   = ctl.wr &  ctl.to_reg;
    assign z_we     = ctl.z_en;
    assign c_we     = ctl.c_en;
    assign dc_we    = ctl.dc_en;
    assign z_out    = ctl.z_en & z_r;
    assign c_out    = ctl.c_en ? c_r : carry_in;
    assign dc_out   = ctl.dc_en & dc_r;
    assign skip     = skip_r;

    always_comb begin
        AST_ONE_DEST: assert (!(acc_we && reg_we))
            else $error("both write strobes high"); // R2
        AST_SKIP_NO_FLAGS: assert (!skip || !(z_we || c_we || dc_we))
            else $error("skip with flag update"); // R6
        AST_TEST_NO_WRITE: assert (!(skip && !acc_we && !reg_we) || instr[IW-1:IW-3] == 3'b011)
            else $error("writeless skip from non bit-test"); // R10
        AST_C_HOLD: assert (c_we || c_out == carry_in)
            else $error("carry changed without enable"); // R11
        AST_Z_MATCH: assert (!z_we || z_out == (result == '0))
            else $error("Z does not reflect result"); // R3
    end
endmodule

// File: tb/tb_acc_alu_core.sv
module tb_acc_alu_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [12:0] instr;
    logic [7:0]  acc_in, reg_in;
    logic        carry_in;
    logic [5:0]  reg_addr;
    logic [7:0]  result;
    logic        dest_reg, acc_we, reg_we, z_out, z_we, c_out, c_we, dc_out, dc_we, skip;

    acc_alu_core dut (
        .instr(instr), .acc_in(acc_in), .reg_in(reg_in), .carry_in(carry_in),
        .reg_addr(reg_addr), .result(result), .dest_reg(dest_reg),
        .acc_we(acc_we), .reg_we(reg_we), .z_out(z_out), .z_we(z_we),
        .c_out(c_out), .c_we(c_we), .dc_out(dc_out), .dc_we(dc_we), .skip(skip)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // Expected {result, acc_we, reg_we, z_we, c_we, dc_we, z, c, dc, skip}
    function automatic logic [16:0] model(input logic [12:0] i, input logic [7:0] a, input logic [7:0] r, input logic ci);
        logic [7:0] res, k;
        logic wr, to_r, zw, cw, dw, c, d, sk;
        logic [8:0] t;
        logic [4:0] h;
        logic [5:0] o;
        res = 0; wr = 0; zw = 0; cw = 0; dw = 0; c = ci; d = 0; sk = 0;
        o = i[11:6]; to_r = i[6]; k = i[7:0];
        if (!i[12]) begin
            if (o[5]) begin
                case (o[4:3])
                    2'd0: begin res = r & ~(8'd1 << i[8:6]); wr = 1; to_r = 1; end
                    2'd1: begin res = r |  (8'd1 << i[8:6]); wr = 1; to_r = 1; end
                    2'd2: sk = ~r[i[8:6]];
                    default: sk = r[i[8:6]];
                endcase
            end else begin
                case (o)
                    6'd1: begin res = a; wr = 1; end
                    6'd2: if (i[5:0] == 0) begin res = 0; wr = 1; zw = 1; end
                    6'd3: begin res = 0; wr = 1; zw = 1; end
                    6'd4, 6'd5: begin
                        t = {1'b0, r} - {1'b0, a}; h = {1'b0, r[3:0]} - {1'b0, a[3:0]};
                        res = t[7:0]; c = ~t[8]; d = ~h[4]; wr = 1; zw = 1; cw = 1; dw = 1;
                    end
                    6'd6, 6'd7:   begin res = r - 1; wr = 1; zw = 1; end
                    6'd8, 6'd9:   begin res = a | r; wr = 1; zw = 1; end
                    6'd10, 6'd11: begin res = a & r; wr = 1; zw = 1; end
                    6'd12, 6'd13: begin res = a ^ r; wr = 1; zw = 1; end
                    6'd14, 6'd15: begin
                        t = a + r; h = a[3:0] + r[3:0];
                        res = t[7:0]; c = t[8]; d = h[4]; wr = 1; zw = 1; cw = 1; dw = 1;
                    end
                    6'd16, 6'd17: begin res = r; wr = 1; zw = 1; end
                    6'd18, 6'd19: begin res = ~r; wr = 1; zw = 1; end
                    6'd20, 6'd21: begin res = r + 1; wr = 1; zw = 1; end
                    6'd22, 6'd23: begin res = r - 1; wr = 1; sk = (r == 8'd1); end
                    6'd24, 6'd25: begin res = {ci, r[7:1]}; c = r[0]; wr = 1; cw = 1; end
                    6'd26, 6'd27: begin res = {r[6:0], ci}; c = r[7]; wr = 1; cw = 1; end
                    6'd28, 6'd29: begin res = {r[3:0], r[7:4]}; wr = 1; end
                    6'd30, 6'd31: begin res = r + 1; wr = 1; sk = (r == 8'hFF); end
                    default: ;
                endcase
            end
        end else begin
            to_r = 0;
            case (i[11:8])
                4'b1000: begin res = k; wr = 1; end
                4'b1001: begin res = a | k; wr = 1; zw = 1; end
                4'b1010: begin res = a & k; wr = 1; zw = 1; end
                4'b1011: begin res = a ^ k; wr = 1; zw = 1; end
                4'b1101: begin
                    t = {1'b0, k} - {1'b0, a}; h = {1'b0, k[3:0]} - {1'b0, a[3:0]};
                    res = t[7:0]; c = ~t[8]; d = ~h[4]; wr = 1; zw = 1; cw = 1; dw = 1;
                end
                4'b1111: begin
                    t = a + k; h = a[3:0] + k[3:0];
                    res = t[7:0]; c = t[8]; d = h[4]; wr = 1; zw = 1; cw = 1; dw = 1;
                end
                default: ;
            endcase
        end
        if (!wr) res = 0;
        if (!cw) c = ci;
        if (!dw) d = 0;
        return {res, wr & ~to_r, wr & to_r, zw, cw, dw, zw & (res == 0), c, d, sk};
    endfunction

    function automatic string req_of(input logic [12:0] i);
        logic [5:0] o;
        o = i[11:6];
        if (i[12]) begin
            case (i[11:8])
                4'b1000: return "R5";
                4'b1001, 4'b1010, 4'b1011: return "R4";
                4'b1101, 4'b1111: return "R3";
                default: return "R1";
            endcase
        end
        if (o[5]) return o[4] ? "R10" : "R9";
        case (o[4:1])
            4'd0: return o[0] ? "R5" : "R1";
            4'd1: return (o[0] || i[5:0] == 0) ? "R5" : "R1";
            4'd2, 4'd7: return "R3";
            4'd4, 4'd5, 4'd6: return "R4";
            4'd11, 4'd15: return "R6";
            4'd12, 4'd13: return "R7";
            4'd14: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic run_case(input string tag, input logic [12:0] i, input logic [7:0] a,
                            input logic [7:0] r, input logic ci);
        logic [16:0] exp, act;
        @(posedge clk);
        instr = i; acc_in = a; reg_in = r; carry_in = ci;
        @(negedge clk);
        exp = model(i, a, r, ci);
        act = {result, acc_we, reg_we, z_we, c_we, dc_we, z_out, c_out, dc_out, skip};
        checks++;
        if (act !== exp || reg_addr !== i[5:0] || dest_reg !== (reg_we | (~acc_we & dest_reg))) begin
            errors++;
            $display("FAIL %s instr=%h a=%h r=%h c=%b actual=%h expected=%h addr=%h",
                     tag, i, a, r, ci, act, exp, reg_addr);
        end
    endtask

    function automatic logic [7:0] pick_byte();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h01;
            3: return 8'h0F;
            default: return 8'($urandom);
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        instr = 0; acc_in = 0; reg_in = 0; carry_in = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        run_case("R1 idle", 13'h0000, 8'h00, 8'h00, 1'b0);
        run_case("R1 clra with addr", 13'h0081, 8'h55, 8'h66, 1'b1);
        run_case("R1 literal 1110", 13'h1E85, 8'h55, 8'h66, 1'b1);
        run_case("R3 add dc", {1'b0, 6'b001110, 6'h05}, 8'h0F, 8'h01, 1'b0);
        run_case("R3 add wrap", {1'b0, 6'b001111, 6'h05}, 8'hFF, 8'h01, 1'b0);
        run_case("R3 sub equal", {1'b0, 6'b000101, 6'h02}, 8'h05, 8'h05, 1'b0);
        run_case("R3 sub borrow", {1'b0, 6'b000100, 6'h02}, 8'h04, 8'h03, 1'b1);
        run_case("R3 literal sub", 13'h1D10, 8'h01, 8'h00, 1'b0);
        run_case("R4 literal or", 13'h19F0, 8'h0F, 8'h00, 1'b1);
        run_case("R5 clra", 13'h0080, 8'h5A, 8'h00, 1'b0);
        run_case("R5 mov a,k", 13'h18AA, 8'h00, 8'h00, 1'b1);
        run_case("R2 mov r,a", {1'b0, 6'b000001, 6'h3F}, 8'hC3, 8'h00, 1'b0);
        run_case("R6 djz hit", {1'b0, 6'b010111, 6'h01}, 8'h00, 8'h01, 1'b0);
        run_case("R6 djz miss", {1'b0, 6'b010110, 6'h01}, 8'h00, 8'h02, 1'b0);
        run_case("R6 jz hit", {1'b0, 6'b011111, 6'h01}, 8'h00, 8'hFF, 1'b1);
        run_case("R7 rrc", {1'b0, 6'b011001, 6'h01}, 8'h00, 8'h01, 1'b1);
        run_case("R7 rlc zero", {1'b0, 6'b011010, 6'h01}, 8'h00, 8'h80, 1'b0);
        run_case("R8 swap", {1'b0, 6'b011100, 6'h01}, 8'h00, 8'h3C, 1'b0);
        run_case("R9 set b7", {4'b0101, 3'd7, 6'h01}, 8'h00, 8'h00, 1'b0);
        run_case("R9 clr b0", {4'b0100, 3'd0, 6'h01}, 8'h00, 8'hFF, 1'b0);
        run_case("R10 test0 hit", {4'b0110, 3'd3, 6'h01}, 8'h00, 8'hF7, 1'b0);
        run_case("R10 test1 miss", {4'b0111, 3'd3, 6'h01}, 8'h00, 8'hF7, 1'b1);
        run_case("R11 carry hold", {1'b0, 6'b001000, 6'h01}, 8'h00, 8'h00, 1'b1);
        for (int n = 0; n < 4000; n++) begin
            logic [12:0] ri;
            ri = 13'($urandom);
            run_case(req_of(ri), ri, pick_byte(), pick_byte(), 1'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule